// File: doc/BRIEF.md
# Saturating Fractional Multiply Unit

This block is the signed fixed-point multiplier of a DSP datapath. Each operation picks two source registers from small fixed subsets. It reads only the upper 16-bit half of each as a signed Q15 fraction and forms the product in one cycle. The product is aligned to the most significant end of a 32-bit word, so bit 0 is always zero. The result is then written to one of four destination registers. Two of those destinations are 40-bit accumulators that carry 8 guard bits above the 32-bit word. The other two are plain 32-bit registers.

The 32-bit source registers arrive as inputs from the surrounding register file. The fourth choice for either source is the low 32 bits of the wide accumulator A1, which this block holds itself. One operand pair cannot be represented: minus one times minus one. A mode input sets how it is handled. With the mode clear, the result wraps to the minimum value. With the mode set, it clamps to the maximum positive fraction. The multiply is unconditional. The block has no status flags, so it cannot disturb any held elsewhere.

Top module: `frmul_unit`

## Requirements
- R1: Source 1 select codes are 0 = X0, 1 = X1, 2 = Y0, 3 = A1 (bits 31:0). Source 2 select codes are 0 = Y0, 1 = Y1, 2 = X0, 3 = A1 (bits 31:0). Destination codes are 0 = M0, 1 = M1, 2 = A0, 3 = A1.
- R2: Only bits 31:16 of each selected source enter the multiply. Bits 15:0 have no effect on any result.
- R3: Outside the saturated case, the 32-bit result equals the signed 16x16 product shifted left by one and truncated to 32 bits. Its bit 0 is zero.
- R4: With sat_mode = 0, 0x8000 times 0x8000 gives 0x8000_0000 in a 32-bit destination and 0x00_8000_0000 in a 40-bit destination.
- R5: With sat_mode = 1, 0x8000 times 0x8000 gives 0x7FFF_FFFF in a 32-bit destination and 0x00_7FFF_FFFF in a 40-bit destination.
- R6: For every case except the one in R4 and R5, bits 39:32 of a 40-bit destination are all copies of result bit 31.
- R7: A 32-bit destination receives exactly the 32-bit result.
- R8: A write takes effect on the first rising clock edge at which mul_valid is sampled high, and it changes only the selected destination. While mul_valid is low, no destination changes.
- R9: While rst_n is low, all four destinations read zero. Release of rst_n takes effect on the second rising edge that follows it.
- R10: sat_mode has no effect on any operand pair other than 0x8000 times 0x8000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_valid | input | 1 | Qualifies a multiply and its destination write |
| sat_mode | input | 1 | 1 = clamp the overflow case, 0 = let it wrap |
| src1_sel | input | 2 | First source select (R1 codes) |
| src2_sel | input | 2 | Second source select (R1 codes) |
| dst_sel | input | 2 | Destination select (R1 codes) |
| x0_in | input | 32 | Register X0 contents |
| x1_in | input | 32 | Register X1 contents |
| y0_in | input | 32 | Register Y0 contents |
| y1_in | input | 32 | Register Y1 contents |
| m0_out | output | 32 | Register M0 |
| m1_out | output | 32 | Register M1 |
| a0_out | output | 40 | Register A0, guard bits in 39:32 |
| a1_out | output | 40 | Register A1, guard bits in 39:32 |

## Verification
The bench aims at the minus-one-squared pair in both modes and into both register widths. A unit that ignored the mode bit, or clamped in both modes, would produce the wrong one of 0x8000_0000 and 0x7FFF_FFFF. A unit that copied bit 31 into the guard bits on overflow would show 0xFF in the top byte. The bench also tests the extremes: maximum times maximum, maximum times minimum, and zero. A missing shift, a lost sign or the wrong guard fill would show up there as a halved value, a wrong sign or a bad top byte. The bench changes only the lower halves of the sources, which catches a unit that reads the wrong half. It also uses A1 as a source after writing to it, which catches a wrong select mapping. It holds mul_valid low and confirms that no register moves. A large randomized run compares all four registers after every operation, so a write to the wrong destination cannot go unnoticed.

// File: rtl/frmul_pkg.sv
`timescale 1ns/1ps
package frmul_pkg;
  // First source operand select
  typedef enum logic [1:0] {
    S1_X0 = 2'd0,
    S1_X1 = 2'd1,
    S1_Y0 = 2'd2,
    S1_A1 = 2'd3
  } src1_e;

  // Second source operand select
  typedef enum logic [1:0] {
    S2_Y0 = 2'd0,
    S2_Y1 = 2'd1,
    S2_X0 = 2'd2,
    S2_A1 = 2'd3
  } src2_e;

  // Destination register select
  typedef enum logic [1:0] {
    D_M0 = 2'd0,
    D_M1 = 2'd1,
    D_A0 = 2'd2,
    D_A1 = 2'd3
  } dst_e;
endpackage

// File: rtl/frmul_opsel.sv
`timescale 1ns/1ps
module frmul_opsel
  import frmul_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  src1_e              sel1,
  input  src2_e              sel2,
  input  logic [DATA_W-1:0]  x0,
  input  logic [DATA_W-1:0]  x1,
  input  logic [DATA_W-1:0]  y0,
  input  logic [DATA_W-1:0]  y1,
  input  logic [DATA_W-1:0]  a1_lo,
  output logic [HALF_W-1:0]  op_a,
  output logic [HALF_W-1:0]  op_b
);
  logic [DATA_W-1:0] word_a;
  logic [DATA_W-1:0] word_b;

  always_comb begin
    unique case (sel1)
      S1_X0:   word_a = x0;
      S1_X1:   word_a = x1;
      S1_Y0:   word_a = y0;
      default: word_a = a1_lo;
    endcase
  end

  always_comb begin
    unique case (sel2)
      S2_Y0:   word_b = y0;
      S2_Y1:   word_b = y1;
      S2_X0:   word_b = x0;
      default: word_b = a1_lo;
    endcase
  end

  // Fractional multiply uses the upper halves only
  assign op_a = word_a[DATA_W-1:HALF_W];
  assign op_b = word_b[DATA_W-1:HALF_W];
endmodule

// File: rtl/frmul_core.sv
`timescale 1ns/1ps
module frmul_core #(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int WIDE_W = DATA_W + GUARD_W
) (
  input  logic [HALF_W-1:0] op_a,
  input  logic [HALF_W-1:0] op_b,
  input  logic              sat_mode,
  output logic [WIDE_W-1:0] result,
  output logic              ovf
);
  localparam logic [HALF_W-1:0] NEG_ONE = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};

  logic signed [DATA_W-1:0] prod;
  logic        [DATA_W-1:0] aligned;
  logic        [DATA_W-1:0] body;
  logic        [GUARD_W-1:0] guard;

  assign prod    = $signed(op_a) * $signed(op_b);
  assign aligned = {prod[DATA_W-2:0], 1'b0};
  assign ovf     = (op_a == NEG_ONE) && (op_b == NEG_ONE);

  always_comb begin
    if (ovf) begin
      body  = sat_mode ? POS_MAX : aligned;
      guard = '0;
    end else begin
      body  = aligned;
      guard = {GUARD_W{aligned[DATA_W-1]}};
    end
  end

  assign result = {guard, body};
endmodule

// File: rtl/frmul_regs.sv
`timescale 1ns/1ps
module frmul_regs
  import frmul_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  localparam int WIDE_W = DATA_W + GUARD_W,
  localparam int N_NARROW = 2,
  localparam int N_WIDE   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  dst_e              wr_sel,
  input  logic [WIDE_W-1:0] wr_data,
  output logic [DATA_W-1:0] m0_q,
  output logic [DATA_W-1:0] m1_q,
  output logic [WIDE_W-1:0] a0_q,
  output logic [WIDE_W-1:0] a1_q
);
  logic [DATA_W-1:0] narrow_q [N_NARROW];
  logic [WIDE_W-1:0] wide_q   [N_WIDE];

  for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
    logic              hit;
    logic [DATA_W-1:0] nxt;
    assign hit = wr_en && (wr_sel == dst_e'(i));
    always_comb nxt = wr_data[DATA_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   narrow_q[i] <= '0;
      else if (hit) narrow_q[i] <= nxt;
    end
  end

  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    logic              hit;
    logic [WIDE_W-1:0] nxt;
    assign hit = wr_en && (wr_sel == dst_e'(j + N_NARROW));
    always_comb nxt = wr_data;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   wide_q[j] <= '0;
      else if (hit) wide_q[j] <= nxt;
    end
  end

  assign m0_q = narrow_q[0];
  assign m1_q = narrow_q[1];
  assign a0_q = wide_q[0];
  assign a1_q = wide_q[1];

  // R8: no write request, no register moves
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(m0_q) && $stable(m1_q) && $stable(a0_q) && $stable(a1_q)));

  // R8: at most one destination changes per write
  assert_single_dest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones({m0_q != $past(m0_q), m1_q != $past(m1_q),
                           a0_q != $past(a0_q), a1_q != $past(a1_q)}) <= 1));
endmodule

// File: rtl/frmul_unit.sv
`timescale 1ns/1ps
module frmul_unit
  import frmul_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int WIDE_W = DATA_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mul_valid,
  input  logic              sat_mode,
  input  logic [1:0]        src1_sel,
  input  logic [1:0]        src2_sel,
  input  logic [1:0]        dst_sel,
  input  logic [DATA_W-1:0] x0_in,
  input  logic [DATA_W-1:0] x1_in,
  input  logic [DATA_W-1:0] y0_in,
  input  logic [DATA_W-1:0] y1_in,
  output logic [DATA_W-1:0] m0_out,
  output logic [DATA_W-1:0] m1_out,
  output logic [WIDE_W-1:0] a0_out,
  output logic [WIDE_W-1:0] a1_out
);
  localparam logic [HALF_W-1:0] NEG_ONE = {1'b1, {(HALF_W-1){1'b0}}};

  // Reset: asynchronous assertion, release through two flops
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [HALF_W-1:0] op_a, op_b;
  logic [WIDE_W-1:0] result;
  logic              ovf;

  frmul_opsel #(.DATA_W(DATA_W)) u_opsel (
    .sel1  (src1_e'(src1_sel)),
    .sel2  (src2_e'(src2_sel)),
    .x0    (x0_in),
    .x1    (x1_in),
    .y0    (y0_in),
    .y1    (y1_in),
    .a1_lo (a1_out[DATA_W-1:0]),
    .op_a  (op_a),
    .op_b  (op_b)
  );

  frmul_core #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_core (
    .op_a     (op_a),
    .op_b     (op_b),
    .sat_mode (sat_mode),
    .result   (result),
    .ovf      (ovf)
  );

  frmul_regs #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (mul_valid),
    .wr_sel  (dst_e'(dst_sel)),
    .wr_data (result),
    .m0_q    (m0_out),
    .m1_q    (m1_out),
    .a0_q    (a0_out),
    .a1_q    (a1_out)
  );

  // R3: a non-clamping write leaves bit 0 clear
  assert_lsb_zero_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mul_valid && !sat_mode && dst_sel == 2'd0) |=> (m0_out[0] == 1'b0));

  // R4: unclamped overflow into a wide register
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mul_valid && !sat_mode && dst_sel == 2'd2 && op_a == NEG_ONE && op_b == NEG_ONE)
    |=> (a0_out == {{GUARD_W{1'b0}}, 1'b1, {(DATA_W-1){1'b0}}}));

  // R5: clamped overflow into a wide register
  assert_clamp_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mul_valid && sat_mode && dst_sel == 2'd3 && op_a == NEG_ONE && op_b == NEG_ONE)
    |=> (a1_out == {{GUARD_W{1'b0}}, 1'b0, {(DATA_W-1){1'b1}}}));

  // R6: guard bits follow bit 31 outside the overflow case
  assert_guard_fill_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (mul_valid && dst_sel == 2'd2 && !ovf)
    |=> (a0_out[WIDE_W-1:DATA_W] == {GUARD_W{a0_out[DATA_W-1]}}));
endmodule

// File: tb/frmul_unit_bench.sv
`timescale 1ns/1ps
module frmul_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mul_valid, sat_mode;
  logic [1:0]  src1_sel, src2_sel, dst_sel;
  logic [31:0] x0_in, x1_in, y0_in, y1_in;
  logic [31:0] m0_out, m1_out;
  logic [39:0] a0_out, a1_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // model of the destination registers
  logic [31:0] e_m0, e_m1;
  logic [39:0] e_a0, e_a1;

  always #5 clk = ~clk;

  frmul_unit u_frmul_unit (
    .clk(clk), .rst_n(rst_n), .mul_valid(mul_valid), .sat_mode(sat_mode),
    .src1_sel(src1_sel), .src2_sel(src2_sel), .dst_sel(dst_sel),
    .x0_in(x0_in), .x1_in(x1_in), .y0_in(y0_in), .y1_in(y1_in),
    .m0_out(m0_out), .m1_out(m1_out), .a0_out(a0_out), .a1_out(a1_out)
  );

  function automatic logic [39:0] ref_mul(logic [15:0] a, logic [15:0] b, logic sat);
    longint p;
    logic [31:0] r;
    if (a == 16'h8000 && b == 16'h8000)
      return sat ? 40'h00_7FFF_FFFF : 40'h00_8000_0000;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    r = p[31:0];
    return {{8{r[31]}}, r};
  endfunction

  function automatic logic [31:0] pick1(logic [1:0] s);
    case (s)
      2'd0: return x0_in;
      2'd1: return x1_in;
      2'd2: return y0_in;
      default: return e_a1[31:0];
    endcase
  endfunction

  function automatic logic [31:0] pick2(logic [1:0] s);
    case (s)
      2'd0: return y0_in;
      2'd1: return y1_in;
      2'd2: return x0_in;
      default: return e_a1[31:0];
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [39:0] act, logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %010h expected %010h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "m0", {8'h0, m0_out}, {8'h0, e_m0});
    chk(tag, "m1", {8'h0, m1_out}, {8'h0, e_m1});
    chk(tag, "a0", a0_out, e_a0);
    chk(tag, "a1", a1_out, e_a1);
  endtask

  // one operation: inputs set at a falling edge, result checked one cycle later
  task automatic do_op(string tag, logic v, logic s, logic [1:0] s1, logic [1:0] s2,
                       logic [1:0] d);
    logic [39:0] r;
    @(negedge clk);
    mul_valid = v; sat_mode = s; src1_sel = s1; src2_sel = s2; dst_sel = d;
    r = ref_mul(pick1(s1)[31:16], pick2(s2)[31:16], s);
    if (v) begin
      case (d)
        2'd0: e_m0 = r[31:0];
        2'd1: e_m1 = r[31:0];
        2'd2: e_a0 = r;
        default: e_a1 = r;
      endcase
    end
    @(negedge clk);
    mul_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [39:0] hold_a1;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; mul_valid = 1'b0; sat_mode = 1'b0;
    src1_sel = 2'd0; src2_sel = 2'd0; dst_sel = 2'd0;
    x0_in = '0; x1_in = '0; y0_in = '0; y1_in = '0;
    e_m0 = '0; e_m1 = '0; e_a0 = '0; e_a1 = '0;
    repeat (3) @(negedge clk);
    check_all("R9");              // reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // zero operand
    x0_in = 32'h0000_1234; y0_in = 32'h4000_0000;
    do_op("R3", 1, 0, 2'd0, 2'd0, 2'd0);
    // max times max into wide register, guard 00
    x0_in = 32'h7FFF_0000; y0_in = 32'h7FFF_0000;
    do_op("R6", 1, 0, 2'd0, 2'd0, 2'd2);
    // max times min into A1, negative, guard FF
    x1_in = 32'h7FFF_0000; y1_in = 32'h8000_0000;
    do_op("R6", 1, 0, 2'd1, 2'd1, 2'd3);
    // minus one squared, wrapping
    y0_in = 32'h8000_0000; x0_in = 32'h8000_FFFF;
    do_op("R4", 1, 0, 2'd2, 2'd2, 2'd2);
    do_op("R7", 1, 0, 2'd2, 2'd2, 2'd1);
    // minus one squared, clamped
    do_op("R5", 1, 1, 2'd2, 2'd2, 2'd3);
    do_op("R5", 1, 1, 2'd0, 2'd0, 2'd0);
    // valid low: nothing changes
    x0_in = 32'h1234_0000; y0_in = 32'h4321_0000;
    do_op("R8", 0, 0, 2'd0, 2'd0, 2'd0);
    do_op("R8", 0, 1, 2'd0, 2'd0, 2'd3);
    // lower halves ignored
    x1_in = 32'hC000_0000; y1_in = 32'h3000_0000;
    do_op("R2", 1, 0, 2'd1, 2'd1, 2'd0);
    x1_in = 32'hC000_FFFF; y1_in = 32'h3000_5A5A;
    do_op("R2", 1, 0, 2'd1, 2'd1, 2'd1);
    chk("R2", "m0 vs m1", {8'h0, m0_out}, {8'h0, m1_out});
    // sat mode without overflow
    do_op("R10", 1, 1, 2'd1, 2'd1, 2'd2);
    // A1 as both sources (R1)
    x0_in = 32'h6000_0000; y0_in = 32'hA000_0000;
    do_op("R1", 1, 0, 2'd0, 2'd0, 2'd3);
    hold_a1 = e_a1;
    do_op("R1", 1, 0, 2'd3, 2'd3, 2'd0);
    do_op("R1", 1, 0, 2'd3, 2'd2, 2'd1);
    chk("R1", "a1 kept", a1_out, hold_a1);

    // randomized mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] hs [4];
      for (int k = 0; k < 4; k++) begin
        case ($urandom_range(0, 5))
          0: hs[k] = 16'h8000;
          1: hs[k] = 16'h7FFF;
          2: hs[k] = 16'h0000;
          default: hs[k] = 16'($urandom);
        endcase
      end
      x0_in = {hs[0], 16'($urandom)};
      x1_in = {hs[1], 16'($urandom)};
      y0_in = {hs[2], 16'($urandom)};
      y1_in = {hs[3], 16'($urandom)};
      do_op((i % 2) ? "R3" : "R8", ($urandom_range(0, 7) != 0), 1'($urandom),
            2'($urandom), 2'($urandom), 2'($urandom));
    end

    // asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    e_m0 = '0; e_m1 = '0; e_a0 = '0; e_a1 = '0;
    check_all("R9");
    finished = 1'b1;
    finish_run();
  end
endmodule